// File: doc/BRIEF.md
# Bipolar Wire-Density Arithmetic Unit

This unit does signed arithmetic on numbers carried as the density of asserted wires in two parallel bundles. A bundle of `WIDTH` wires with `n` wires at logic one holds the fraction X = n/WIDTH. That fraction stands for the signed value Y = 2X - 1, which lies between -1 and +1. Flipping every wire of a bundle negates its value. From two such bundles the unit produces three result bundles in the same cycle: a product, a half-scaled sum and a half-scaled difference. It uses only per-wire coincidence gates, inversions and fixed wire routing, with no binary adders.

The operand bundles enter active-low: a low pin means logic one. The three result bundles leave active-high. The product gate gives the same answer under either polarity. Every routed sum or difference wire gets a polarity correction. The sum and difference each take half of every operand through a routing map fixed at elaboration time. Result wire k takes operand A wire 2k when k is below WIDTH/2. Otherwise it takes operand B wire 2(k-WIDTH/2)+1. The other half of each operand has no effect on those two results.

Operands and results move as one stream beat under a valid/ready handshake. The unit holds no state, so it passes the handshake straight through. `res_valid` follows `opd_valid`, and `opd_ready` follows `res_ready`, in the same cycle. A beat transfers in a cycle where both valid and ready are high. Back-pressure from the consumer reaches the producer with no delay. Result data is meaningful only while `res_valid` is high.

Top module: `bpa_unit`

## Requirements
- R1: Product wire k is 1 exactly when operand A wire k and operand B wire k carry the same logic level. Logic one on an operand wire is a low pin.
- R2: The ones-count of the product equals WIDTH minus the number of positions where the `opd_a_n` and `opd_b_n` pins differ. For independent operands its mean density tracks (1 + Y1·Y2)/2 within 3 percent over many beats.
- R3: For k < WIDTH/2, sum wire k equals the logic level of operand A wire 2k, which is the inverse of pin `opd_a_n[2k]`.
- R4: For k >= WIDTH/2, sum wire k equals the logic level of operand B wire 2(k-WIDTH/2)+1.
- R5: For k < WIDTH/2, difference wire k equals sum wire k.
- R6: For k >= WIDTH/2, difference wire k is the inverse of the logic level of operand B wire 2(k-WIDTH/2)+1. That wire is the subtrahend, negated.
- R7: The odd wires of operand A and the even wires of operand B have no effect on the sum or difference bundles.
- R8: `res_valid` equals `opd_valid` and `opd_ready` equals `res_ready` in the same cycle, whatever the data.
- R9: At full scale the values combine as expected. A = +1 (all pins low) with B = -1 (all pins high) gives a product count of 0, a sum count of WIDTH/2 and a difference count of WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_valid | input | 1 | Operand beat present |
| opd_ready | output | 1 | Unit can take the operand beat |
| opd_a_n | input | WIDTH | Operand A bundle, active-low |
| opd_b_n | input | WIDTH | Operand B bundle, active-low |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Consumer takes the result beat |
| res_prod | output | WIDTH | Product bundle, active-high |
| res_sum | output | WIDTH | Half-scaled sum bundle, active-high |
| res_diff | output | WIDTH | Half-scaled difference bundle, active-high |

## Verification
The hardest thing to show from the pins is that the unrouted half of each operand really has no influence. A change there moves the product, so comparing whole-bundle counts cannot isolate it. The stimulus therefore holds the routed wires fixed and toggles only the odd A wires and the even B wires. It then compares the sum and difference bundles wire by wire against values the bench builds from the routing rule. The statistical product check draws bundles with random densities and compares the accumulated count against the ideal formula taken from the actual operand counts.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  // Parity lanes of a bundle: lane 0 holds the even wires, lane 1 the odd wires.
  localparam int unsigned LANES = 2;

  // Index of the bundle wire that feeds position k of a parity lane.
  function automatic int unsigned lane_wire(input int unsigned k, input int unsigned parity);
    return 2 * k + parity;
  endfunction
endpackage

// File: rtl/bpa_split.sv
module bpa_split #(
  parameter int unsigned WIDTH = 100,
  localparam int unsigned HALF = WIDTH / 2
) (
  input  logic [WIDTH-1:0] bundle,
  output logic [HALF-1:0]  even_lane,
  output logic [HALF-1:0]  odd_lane
);
  import bpa_pkg::*;

  for (genvar k = 0; k < HALF; k++) begin : g_lane
    assign even_lane[k] = bundle[lane_wire(k, 0)];
    assign odd_lane[k]  = bundle[lane_wire(k, 1)];
  end
endmodule

// File: rtl/bpa_coincide.sv
module bpa_coincide #(
  parameter int unsigned LEN = 50
) (
  input  logic [LEN-1:0] x,
  input  logic [LEN-1:0] y,
  output logic [LEN-1:0] agree
);
  for (genvar k = 0; k < LEN; k++) begin : g_gate
    // Equality of levels is polarity-independent, so raw pins may feed it.
    assign agree[k] = ~(x[k] ^ y[k]);
  end
endmodule

// File: rtl/bpa_merge.sv
module bpa_merge #(
  parameter int unsigned HALF    = 50,
  parameter bit          NEGATE2 = 1'b0,
  localparam int unsigned WIDTH  = 2 * HALF
) (
  input  logic [HALF-1:0]  first_n,
  input  logic [HALF-1:0]  second_n,
  output logic [WIDTH-1:0] merged
);
  // Active-low pins become active-high by inversion; a negated second
  // operand cancels that inversion, so its pin passes straight through.
  assign merged[HALF-1:0] = ~first_n;

  if (NEGATE2) begin : g_neg
    assign merged[WIDTH-1:HALF] = second_n;
  end else begin : g_pos
    assign merged[WIDTH-1:HALF] = ~second_n;
  end
endmodule

// File: rtl/bpa_unit.sv
module bpa_unit #(
  parameter int unsigned WIDTH = 100,
  localparam int unsigned HALF = WIDTH / 2
) (
  input  logic             opd_valid,
  output logic             opd_ready,
  input  logic [WIDTH-1:0] opd_a_n,
  input  logic [WIDTH-1:0] opd_b_n,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [WIDTH-1:0] res_prod,
  output logic [WIDTH-1:0] res_sum,
  output logic [WIDTH-1:0] res_diff
);
  import bpa_pkg::*;

  logic [HALF-1:0] a_lane [LANES];
  logic [HALF-1:0] b_lane [LANES];
  logic [HALF-1:0] p_lane [LANES];

  // Stateless unit: the handshake passes straight through.
  assign res_valid = opd_valid;
  assign opd_ready = res_ready;

  bpa_split #(.WIDTH(WIDTH)) u_split_a (
    .bundle(opd_a_n), .even_lane(a_lane[0]), .odd_lane(a_lane[1]));
  bpa_split #(.WIDTH(WIDTH)) u_split_b (
    .bundle(opd_b_n), .even_lane(b_lane[0]), .odd_lane(b_lane[1]));

  for (genvar p = 0; p < LANES; p++) begin : g_par
    bpa_coincide #(.LEN(HALF)) u_coin (
      .x(a_lane[p]), .y(b_lane[p]), .agree(p_lane[p]));
    for (genvar k = 0; k < HALF; k++) begin : g_back
      assign res_prod[lane_wire(k, p)] = p_lane[p][k];
    end
  end

  bpa_merge #(.HALF(HALF), .NEGATE2(1'b0)) u_sum (
    .first_n(a_lane[0]), .second_n(b_lane[1]), .merged(res_sum));
  bpa_merge #(.HALF(HALF), .NEGATE2(1'b1)) u_diff (
    .first_n(a_lane[0]), .second_n(b_lane[1]), .merged(res_diff));
endmodule

// File: rtl/bpa_unit_chk.sv
module bpa_unit_chk #(
  parameter int unsigned WIDTH = 100,
  localparam int unsigned HALF = WIDTH / 2
) (
  input logic             opd_valid,
  input logic             opd_ready,
  input logic [WIDTH-1:0] opd_a_n,
  input logic [WIDTH-1:0] opd_b_n,
  input logic             res_valid,
  input logic             res_ready,
  input logic [WIDTH-1:0] res_prod,
  input logic [WIDTH-1:0] res_sum,
  input logic [WIDTH-1:0] res_diff
);
  always_comb begin
    p_prod_count_r2: assert ($countones(res_prod) == WIDTH - $countones(opd_a_n ^ opd_b_n))
      else $error("product count mismatch");
    p_hs_valid_r8: assert (res_valid == opd_valid) else $error("valid not passed");
    p_hs_ready_r8: assert (opd_ready == res_ready) else $error("ready not passed");
    for (int k = 0; k < HALF; k++) begin
      p_sum_lo_r3: assert (res_sum[k] == !opd_a_n[2*k]) else $error("sum low half");
      p_sum_hi_r4: assert (res_sum[HALF+k] == !opd_b_n[2*k+1]) else $error("sum high half");
      p_diff_lo_r5: assert (res_diff[k] == res_sum[k]) else $error("diff low half");
      p_diff_neg_r6: assert (res_diff[HALF+k] != res_sum[HALF+k]) else $error("diff not negated");
    end
    for (int k = 0; k < WIDTH; k++) begin
      p_prod_wire_r1: assert (res_prod[k] == (opd_a_n[k] == opd_b_n[k])) else $error("product wire");
    end
  end
endmodule

bind bpa_unit bpa_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .opd_valid(opd_valid), .opd_ready(opd_ready), .opd_a_n(opd_a_n), .opd_b_n(opd_b_n),
  .res_valid(res_valid), .res_ready(res_ready), .res_prod(res_prod),
  .res_sum(res_sum), .res_diff(res_diff));

// File: tb/bpa_unit_tb.sv
`timescale 1ns/1ps
module bpa_unit_tb;
  localparam int W = 100;
  localparam int H = W / 2;

  typedef struct packed {
    logic [W-1:0] a_n;
    logic [W-1:0] b_n;
    logic [7:0]   prod;
    logic [7:0]   sum;
    logic [7:0]   diff;
  } vec_t;

  localparam vec_t TABLE [8] = '{
    '{{W{1'b0}}, {W{1'b0}}, 8'd100, 8'd100, 8'd50},
    '{{W{1'b1}}, {W{1'b1}}, 8'd100, 8'd0,   8'd50},
    '{{W{1'b0}}, {W{1'b1}}, 8'd0,   8'd50,  8'd100},
    '{{W{1'b1}}, {W{1'b0}}, 8'd0,   8'd50,  8'd0},
    '{{50{2'b01}}, {W{1'b0}}, 8'd50, 8'd50, 8'd0},
    '{{50{2'b10}}, {50{2'b01}}, 8'd0, 8'd100, 8'd50},
    '{{50{2'b01}}, {50{2'b10}}, 8'd0, 8'd0,   8'd50},
    '{{{90{1'b0}}, {10{1'b1}}}, {{50{1'b1}}, {50{1'b0}}}, 8'd40, 8'd70, 8'd70}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         opd_valid = 1'b0, res_ready = 1'b0;
  logic         opd_ready, res_valid;
  logic [W-1:0] opd_a_n = '0, opd_b_n = '0;
  logic [W-1:0] res_prod, res_sum, res_diff;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  bpa_unit #(.WIDTH(W)) u_dut (
    .opd_valid(opd_valid), .opd_ready(opd_ready), .opd_a_n(opd_a_n), .opd_b_n(opd_b_n),
    .res_valid(res_valid), .res_ready(res_ready), .res_prod(res_prod),
    .res_sum(res_sum), .res_diff(res_diff));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    opd_a_n = a;
    opd_b_n = b;
    #1;
  endtask

  // Expected bundles built from the routing and polarity rules.
  function automatic logic [W-1:0] exp_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    for (int k = 0; k < H; k++) begin
      r[k] = ~a[2*k];
      r[H+k] = ~b[2*k+1];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] exp_diff(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    for (int k = 0; k < H; k++) begin
      r[k] = ~a[2*k];
      r[H+k] = b[2*k+1];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] rand_bundle(input int dens_pct);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (($urandom % 100) < dens_pct);
    return r;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, a2, b2;
    real acc_act, acc_ideal;
    // Idle state: no beat offered (R8)
    #1;
    check("R8 idle valid", res_valid, 0);
    check("R8 idle ready", opd_ready, 0);

    // Table walk: R1 R2 R3 R4 R5 R6 R9
    for (int t = 0; t < 8; t++) begin
      drive(TABLE[t].a_n, TABLE[t].b_n);
      check("R2 product count", $countones(res_prod), TABLE[t].prod);
      check("R3 R4 sum count", $countones(res_sum), TABLE[t].sum);
      check("R5 R6 diff count", $countones(res_diff), TABLE[t].diff);
    end

    // Full-scale corner: A=+1, B=-1 (R9)
    drive({W{1'b0}}, {W{1'b1}});
    check("R9 product", $countones(res_prod), 0);
    check("R9 sum", $countones(res_sum), H);
    check("R9 diff", $countones(res_diff), W);

    // Handshake pass-through (R8)
    @(negedge clk); opd_valid = 1'b1; res_ready = 1'b0; #1;
    check("R8 valid high", res_valid, 1);
    check("R8 ready low", opd_ready, 0);
    @(negedge clk); opd_valid = 1'b0; res_ready = 1'b1; #1;
    check("R8 valid low", res_valid, 0);
    check("R8 ready high", opd_ready, 1);

    // Per-wire product and routing on random data (R1 R3 R4 R5 R6)
    for (int t = 0; t < 20; t++) begin
      a = rand_bundle(50);
      b = rand_bundle(50);
      drive(a, b);
      check("R1 product wires", res_prod, ~(a ^ b));
      check("R3 R4 sum wires", res_sum, exp_sum(a, b));
      check("R5 R6 diff wires", res_diff, exp_diff(a, b));
    end

    // Unrouted wires toggled alone (R7)
    for (int t = 0; t < 10; t++) begin
      a = rand_bundle(40);
      b = rand_bundle(60);
      a2 = a ^ {50{2'b10}};
      b2 = b ^ {50{2'b01}};
      drive(a2, b2);
      check("R7 sum unaffected", res_sum, exp_sum(a, b));
      check("R7 diff unaffected", res_diff, exp_diff(a, b));
    end

    // Mean product density against the ideal (R2)
    acc_act = 0.0;
    acc_ideal = 0.0;
    for (int t = 0; t < 300; t++) begin
      int n1, n2;
      a = rand_bundle(int'($urandom % 101));
      b = rand_bundle(int'($urandom % 101));
      drive(a, b);
      n1 = W - $countones(a);
      n2 = W - $countones(b);
      acc_act += $countones(res_prod);
      acc_ideal += real'(n1 * n2 + (W - n1) * (W - n2)) / W;
    end
    checks++;
    if ((acc_act - acc_ideal) > 0.03 * 300 * W || (acc_ideal - acc_act) > 0.03 * 300 * W) begin
      errors++;
      $display("FAIL R2 mean product actual=%0f expected=%0f", acc_act, acc_ideal);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule